// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block is the consumer side of a small ring of receive descriptors kept in a word-addressed memory. Each descriptor is four 32-bit words: a status word, a length/control word, a buffer byte address and a byte pointer to the next descriptor. A producer fills a buffer and clears the ownership bit in the status word. The consumer then reads that status and sorts the completed frame into one of four outcomes: good, multi-buffer (oversize), fatal error, or not ready.

A one-cycle `init_start` pulse makes the block write every descriptor and give each one to the producer. After that, each accepted `poll` pulse inspects the descriptor at the current ring index and ends with a one-cycle `done` pulse. For a good frame, `frame_valid` is also high, with the frame length (CRC excluded) and the buffer byte address. A good entry is handed back to the producer by rewriting its status word, and the index then advances. The block does not move payload bytes.

Memory timing: a read issued with `mem_en` high and `mem_we` low returns its word on `mem_rdata` in the next cycle. A write takes effect at the clock edge.

Top module: `rx_ring_walker`

## Requirements
- R1: On `init_start`, each entry e (word base DESC_BASE+4e) gets four writes:
  - word 1: BUF_BYTES, with bit 25 also set only on the last entry;
  - word 2: BUF_BASE + e*BUF_BYTES;
  - word 3: the byte address (word address times 4) of the descriptor of entry (e+1) mod RING_ENTRIES;
  - word 0: 0x80000000, written after the other three words of that entry.
  The ring index returns to entry 0.
- R2: If status bit 31 is set when polled, the block gives `done` with no other flag. It writes no memory and keeps the ring index.
- R3: A status whose AND with 0x38008300 equals 0x00000300 is a good frame. `done` and `frame_valid` rise together, `frame_len` = status[26:16] - 4, and `frame_buf` = word 2 of the entry.
- R4: For a good frame, the block writes 0x80000000 to the entry's status word. The index then advances by one, wrapping from the last entry to entry 0.
- R5: A status whose AND with 0x38000300 is not 0x00000300, and whose low 16 bits are not 0x7FFF, gives `done` with `oversize`. There is no write-back, and the index advances.
- R6: A status matching the R5 mask test but with low 16 bits equal to 0x7FFF gives `done` with no flag. There is no write-back, and the index advances.
- R7: A status that passes the 0x38000300 test but fails the good test (bit 15 set) gives `done` with `reset_req`. There is no frame, no write-back, and the index is unchanged.
- R8: A `poll` or `init_start` while `ready` is low is ignored. Each accepted poll gives exactly one `done`. At most one of `frame_valid`, `oversize` and `reset_req` is high, and only together with `done`.
- R9: After reset, `ready` is high, all result pulses are low, and the index is entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_start | input | 1 | Pulse: build the ring and give all entries to the producer |
| poll | input | 1 | Pulse: inspect the current descriptor |
| ready | output | 1 | High when a poll or init can be accepted |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| done | output | 1 | One-cycle end of a poll |
| frame_valid | output | 1 | Good frame delivered with this `done` |
| frame_len | output | 11 | Frame length without the 4 CRC bytes |
| frame_buf | output | 32 | Byte address of the frame buffer |
| oversize | output | 1 | Frame spread over several buffers |
| reset_req | output | 1 | Fatal receive error; the ring must be rebuilt |

## Verification
The checks that run on every cycle cover the following:
- the result flags are mutually exclusive and only appear with `done`;
- `done` never appears on two cycles in a row;
- memory writes happen only while busy;
- every delivered frame was preceded by a write of the bare ownership word;
- the index moves as expected: one step with wrap after a good frame or oversize, and no move on a fatal error.

The ring contents after initialisation and the write order inside each entry are shown only by the bench's scenarios. So are the exact length arithmetic, the buffer address per entry, the absence of write-back on rejected frames, the silent skip on the 0x7FFF pattern, and the behaviour when polls arrive while the block is busy.

// File: rtl/rx_ring_walker.sv
module rx_ring_walker #(
  parameter int          RING_ENTRIES = 2,
  parameter int          BUF_BYTES    = 1536,
  parameter int          AW           = 8,
  parameter int          DESC_BASE    = 0,
  parameter logic [31:0] BUF_BASE     = 32'h0001_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_start,
  input  logic          poll,
  output logic          ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic          frame_valid,
  output logic [10:0]   frame_len,
  output logic [31:0]   frame_buf,
  output logic          oversize,
  output logic          reset_req
);
  localparam int IW = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1;
  localparam int CW = IW + 2;
  localparam logic [CW-1:0] INIT_LAST = CW'(4 * RING_ENTRIES - 1);
  localparam logic [IW-1:0] LAST_ENTRY = IW'(RING_ENTRIES - 1);
  localparam logic [31:0] OWNED     = 32'h8000_0000;
  localparam logic [31:0] END_RING  = 32'h0200_0000;
  localparam logic [31:0] GOOD_MASK = 32'h3800_8300;
  localparam logic [31:0] EDGE_MASK = 32'h3800_0300;
  localparam logic [31:0] EDGE_OK   = 32'h0000_0300;

  typedef enum logic [2:0] {ST_IDLE, ST_INIT, ST_STAT, ST_DECODE, ST_BUFRD, ST_REL} state_t;

  state_t        state;
  logic [IW-1:0] rd_idx;
  logic [CW-1:0] init_cnt;

  wire [IW-1:0] init_entry = init_cnt[CW-1:2];
  wire [1:0]    init_word  = init_cnt[1:0] + 2'd1;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] e);
    return (e == LAST_ENTRY) ? '0 : e + 1'b1;
  endfunction

  function automatic logic [AW-1:0] desc_at(input logic [IW-1:0] e);
    return AW'(DESC_BASE) + AW'({e, 2'b00});
  endfunction

  assign ready = (state == ST_IDLE);

  wire        is_owned = mem_rdata[31];
  wire        is_good  = (mem_rdata & GOOD_MASK) == EDGE_OK;
  wire        is_split = (mem_rdata & EDGE_MASK) != EDGE_OK;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_INIT: begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = desc_at(init_entry) + AW'(init_word);
        case (init_word)
          2'd0: mem_wdata = OWNED;
          2'd1: mem_wdata = 32'(BUF_BYTES) | ((init_entry == LAST_ENTRY) ? END_RING : 32'h0);
          2'd2: mem_wdata = BUF_BASE + 32'(init_entry) * 32'(BUF_BYTES);
          default: mem_wdata = 32'(desc_at(step(init_entry))) << 2;
        endcase
      end
      ST_STAT: begin
        mem_en   = 1'b1;
        mem_addr = desc_at(rd_idx);
      end
      ST_BUFRD: begin
        mem_en   = 1'b1;
        mem_addr = desc_at(rd_idx) + AW'(2);
      end
      ST_REL: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_at(rd_idx);
        mem_wdata = OWNED;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      rd_idx      <= '0;
      init_cnt    <= '0;
      done        <= 1'b0;
      frame_valid <= 1'b0;
      oversize    <= 1'b0;
      reset_req   <= 1'b0;
      frame_len   <= '0;
      frame_buf   <= '0;
    end else begin
      done        <= 1'b0;
      frame_valid <= 1'b0;
      oversize    <= 1'b0;
      reset_req   <= 1'b0;
      case (state)
        ST_IDLE:
          if (init_start) begin
            state    <= ST_INIT;
            init_cnt <= '0;
            rd_idx   <= '0;
          end else if (poll) begin
            state <= ST_STAT;
          end
        ST_INIT:
          if (init_cnt == INIT_LAST) state <= ST_IDLE;
          else init_cnt <= init_cnt + 1'b1;
        ST_STAT: state <= ST_DECODE;
        ST_DECODE:
          if (is_owned) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (is_good) begin
            frame_len <= mem_rdata[26:16] - 11'd4;
            state     <= ST_BUFRD;
          end else if (is_split) begin
            done     <= 1'b1;
            oversize <= (mem_rdata[15:0] != 16'h7FFF);
            rd_idx   <= step(rd_idx);
            state    <= ST_IDLE;
          end else begin
            done      <= 1'b1;
            reset_req <= 1'b1;
            state     <= ST_IDLE;
          end
        ST_BUFRD: state <= ST_REL;
        ST_REL: begin
          frame_buf   <= mem_rdata;
          frame_valid <= 1'b1;
          done        <= 1'b1;
          rd_idx      <= step(rd_idx);
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_walker_chk.sv
module rx_ring_walker_chk #(
  parameter int RING_ENTRIES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ready,
  input logic        done,
  input logic        frame_valid,
  input logic        oversize,
  input logic        reset_req,
  input logic        mem_en,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic [((RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1)-1:0] idx
);
  localparam int IW = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1;
  localparam logic [IW-1:0] LAST_ENTRY = IW'(RING_ENTRIES - 1);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_valid, oversize, reset_req}));

  assert_flags_need_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid || oversize || reset_req) |-> done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_write_when_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && !ready));

  assert_release_before_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(mem_we && mem_wdata == 32'h8000_0000));

  assert_advance_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> idx == (($past(idx) == LAST_ENTRY) ? '0 : $past(idx) + 1'b1));

  assert_advance_on_oversize_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oversize |-> idx == (($past(idx) == LAST_ENTRY) ? '0 : $past(idx) + 1'b1));

  assert_hold_on_fatal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> idx == $past(idx));
endmodule

bind rx_ring_walker rx_ring_walker_chk #(.RING_ENTRIES(RING_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .done(done),
  .frame_valid(frame_valid), .oversize(oversize), .reset_req(reset_req),
  .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata), .idx(rd_idx)
);

// File: tb/rx_ring_walker_bench.sv
module rx_ring_walker_bench;
  localparam int          N    = 2;
  localparam int          BB   = 1536;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0, rst_n = 1'b0, init_start = 1'b0, poll = 1'b0;
  logic ready, mem_en, mem_we, done, frame_valid, oversize, reset_req;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata, frame_buf;
  logic [10:0] frame_len;

  always #10 clk = ~clk;

  rx_ring_walker u_rx_ring_walker (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .poll(poll), .ready(ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .frame_valid(frame_valid), .frame_len(frame_len),
    .frame_buf(frame_buf), .oversize(oversize), .reset_req(reset_req)
  );

  logic [31:0] mem [64];
  int          wseq [64];
  int          wcount = 0;
  logic        tb_we = 1'b0;
  logic [5:0]  tb_a = '0;
  logic [31:0] tb_d = '0;

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    if (mem_en && mem_we) begin
      mem[mem_addr[5:0]]  <= mem_wdata;
      wseq[mem_addr[5:0]] <= wcount;
      wcount <= wcount + 1;
    end else if (mem_en) begin
      mem_rdata <= mem[mem_addr[5:0]];
    end
  end

  typedef struct { bit fv; bit ov; bit rr; logic [10:0] len; logic [31:0] baddr; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8: actual unexpected done expected none");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " flags"}, {29'd0, frame_valid, oversize, reset_req}, {29'd0, e.fv, e.ov, e.rr});
        if (e.fv) begin
          chk({e.tag, " len"}, {21'd0, frame_len}, {21'd0, e.len});
          chk({e.tag, " buf"}, frame_buf, e.baddr);
        end
      end
    end
  end

  task automatic poke(int a, logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_a = 6'(a); tb_d = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic exp_poll(bit fv, bit ov, bit rr, int len, int entry, string tag, int cycles);
    exp_t e;
    e.fv = fv; e.ov = ov; e.rr = rr; e.len = 11'(len);
    e.baddr = BASE + 32'(entry * BB); e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk); poll = 1'b1;
    repeat (cycles) @(negedge clk);
    poll = 1'b0;
    while (exp_q.size() != 0 || !ready) @(negedge clk);
  endtask

  function automatic logic [31:0] good(int l);
    return (32'(l) << 16) | 32'h300;
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 ready", {31'd0, ready}, 32'd1);
    chk("R9 pulses", {28'd0, done, frame_valid, oversize, reset_req}, 32'd0);

    @(negedge clk); init_start = 1'b1;
    @(negedge clk); init_start = 1'b0;
    while (!ready) @(negedge clk);
    for (int e = 0; e < N; e++) begin
      chk("R1 status", mem[4*e], 32'h8000_0000);
      chk("R1 length", mem[4*e+1], 32'(BB) | ((e == N-1) ? 32'h0200_0000 : 32'h0));
      chk("R1 bufaddr", mem[4*e+2], BASE + 32'(e * BB));
      chk("R1 next", mem[4*e+3], 32'(((e + 1) % N) * 4) << 2);
      chk("R1 order", {31'd0, wseq[4*e] > wseq[4*e+1] && wseq[4*e] > wseq[4*e+2] && wseq[4*e] > wseq[4*e+3]}, 32'd1);
    end

    exp_poll(0, 0, 0, 0, 0, "R2 owned", 1);
    chk("R2 no write", mem[0], 32'h8000_0000);

    poke(0, good(68));
    exp_poll(1, 0, 0, 64, 0, "R3 good e0", 1);
    chk("R4 release e0", mem[0], 32'h8000_0000);

    poke(4, good(1522));
    exp_poll(1, 0, 0, 1518, 1, "R3 good e1", 1);
    poke(0, good(100));
    exp_poll(1, 0, 0, 96, 0, "R4 wrap", 1);

    poke(4, 32'h0000_0123);
    exp_poll(0, 1, 0, 0, 0, "R5 oversize", 1);
    chk("R5 no write", mem[4], 32'h0000_0123);

    poke(0, 32'h1000_7FFF);
    exp_poll(0, 0, 0, 0, 0, "R6 skip", 1);
    chk("R6 no write", mem[0], 32'h1000_7FFF);

    poke(4, 32'h0040_8300);
    exp_poll(0, 0, 1, 0, 0, "R7 fatal", 1);
    chk("R7 no write", mem[4], 32'h0040_8300);
    poke(4, good(60));
    exp_poll(1, 0, 0, 56, 1, "R7 index held", 1);

    poke(0, good(200));
    exp_poll(1, 0, 0, 196, 0, "R8 busy poll", 3);
    repeat (10) @(negedge clk);
    poke(4, good(80));
    exp_poll(1, 0, 0, 76, 1, "R8 single advance", 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule